// File: doc/BRIEF.md
# Manchester Receive Decoder with Nibble/Serial Output

This block takes the sampled line of a 10 Mb/s Manchester receive path and turns it into NRZ data for a media-independent interface. The line is sampled at `OSR` ticks per bit, marked by the `os_en` enable in the fast core clock domain. The block locks its half-bit phase to the transition that each Manchester bit carries at its centre. It ignores the transitions that fall on bit boundaries and re-aligns its phase counter on every centre transition it accepts. The bit value is the line level after that transition: a rising centre edge is a 1.

Carrier sense goes high once a run of well-spaced centre transitions shows that a real stream is present. It stays high until the line has been quiet for more than two bit times. While carrier sense is high, decoded bits go out in one of two forms. In nibble form, four bits are packed into one word with the earliest bit in the lowest position. In serial form, each bit goes out alone on the lowest data line. Each word or bit comes with a one-clock `rx_valid` strobe. When carrier drops, any partly filled nibble is thrown away and the data lines return to zero.

Top module: `mrx_manchester_rx`

## Requirements
- R1: The line is read only on clocks with `os_en` high. A change of level is taken as a centre transition if no phase reference is held, or if at least `3*OSR/4` ticks have passed since the last accepted centre transition. Earlier changes are bit-boundary transitions and are ignored. The decoded bit equals `line_in` after the accepted transition (low-to-high gives 1).
- R2: With `serial_mode`=0, delivered bits are packed four at a time. The first delivered bit goes to `rxd[0]` and the fourth to `rxd[3]`. The word appears with `rx_valid` high for exactly one clock, on the clock after the tick that carried the fourth bit.
- R3: With `serial_mode`=1, each delivered bit appears on `rxd[0]` with `rxd[3:1]`=0 and `rx_valid` high for one clock, on the clock after its tick.
- R4: `crs` rises on the clock after the accepted centre transition that closes the `CS_RUN`-th consecutive gap of at most `5*OSR/4` ticks. A longer gap restarts the count. The bit of the transition that raises `crs` is not delivered; delivery begins with the next bit.
- R5: When `2*OSR+1` ticks pass with no accepted centre transition, `crs` falls on the next clock. The phase reference is lost, and a partly collected nibble is discarded, so the next frame starts a fresh word.
- R6: While `crs` is low, `rxd` is all zero and `rx_valid` is low.
- R7: After reset, `crs`, `rx_valid` and `rxd` are all zero, and the line is taken to have been low.
- R8: Because the phase is re-aligned on every accepted centre transition, a bit whose centre arrives up to `OSR/4` ticks late still decodes correctly, and the bits after it decode correctly too.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock, faster than the sample rate |
| rst_n | input | 1 | Active-low synchronous reset |
| os_en | input | 1 | Sample tick enable, `OSR` ticks per bit |
| line_in | input | 1 | Sampled Manchester receive line |
| serial_mode | input | 1 | 1: one bit per strobe on `rxd[0]`; 0: four-bit words |
| rxd | output | 4 | Receive data word |
| rx_valid | output | 1 | One-clock strobe marking new `rxd` |
| crs | output | 1 | Carrier sense |

## Verification
A wrong phase counter shows up at the ports within one bit time. A boundary transition is taken as a centre transition, or a centre transition is missed, and the next strobed value is an inverted or shifted bit. A wrong carrier run count moves the rise of `crs` by a whole bit, so the first delivered nibble has a different content. A stale nibble index survives a carrier drop and only shows at the first word of the next frame, about four bit times after that frame gains carrier. For this reason the frames are compared clock by clock against a behavioural model and word by word against the transmitted bits.

// File: rtl/mrx_pkg.sv
package mrx_pkg;

  // Earliest tick count at which a level change counts as a centre transition.
  function automatic int unsigned early_gap(input int unsigned osr);
    return (3 * osr) / 4;
  endfunction

  // Longest gap still counted as part of a valid carrier run.
  function automatic int unsigned late_gap(input int unsigned osr);
    return (5 * osr) / 4;
  endfunction

  // Gap beyond which the stream is declared finished.
  function automatic int unsigned quiet_gap(input int unsigned osr);
    return 2 * osr;
  endfunction

endpackage

// File: rtl/mrx_edge_track.sv
module mrx_edge_track #(
  parameter int unsigned OSR   = 8,
  parameter int unsigned CNT_W = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic os_en,
  input  logic line_in,
  output logic mid_evt,
  output logic mid_val,
  output logic gap_ok,
  output logic quiet,
  output logic locked
);
  import mrx_pkg::*;

  localparam logic [CNT_W-1:0] EARLY_C = CNT_W'(early_gap(OSR));
  localparam logic [CNT_W-1:0] LATE_C  = CNT_W'(late_gap(OSR));
  localparam logic [CNT_W-1:0] QUIET_C = CNT_W'(quiet_gap(OSR));

  logic             last_q;
  logic [CNT_W-1:0] cnt_q;
  logic             lock_q;
  logic [CNT_W-1:0] gap;
  logic             toggled;

  // Ticks since the last accepted centre transition, counting this one.
  assign gap     = (&cnt_q) ? cnt_q : cnt_q + 1'b1;
  assign toggled = os_en && (line_in != last_q);
  assign mid_evt = toggled && (!lock_q || gap >= EARLY_C);
  assign mid_val = line_in;
  assign gap_ok  = lock_q && (gap <= LATE_C);
  assign quiet   = os_en && !mid_evt && lock_q && (gap > QUIET_C);
  assign locked  = lock_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      last_q <= 1'b0;
      cnt_q  <= '0;
      lock_q <= 1'b0;
    end else if (os_en) begin
      last_q <= line_in;
      if (mid_evt) begin
        cnt_q  <= '0;
        lock_q <= 1'b1;
      end else begin
        cnt_q <= gap;
        if (quiet) lock_q <= 1'b0;
      end
    end
  end

  assert_quiet_unlocks_R5: assert property (@(posedge clk) disable iff (!rst_n)
    quiet |=> !locked);

  assert_mid_only_on_tick_R1: assert property (@(posedge clk) disable iff (!rst_n)
    mid_evt |-> os_en);

endmodule

// File: rtl/mrx_carrier.sv
module mrx_carrier #(
  parameter int unsigned CS_RUN = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mid_evt,
  input  logic gap_ok,
  input  logic quiet,
  output logic crs,
  output logic bit_evt
);
  localparam int unsigned RUN_W = $clog2(CS_RUN + 1);
  localparam logic [RUN_W-1:0] RUN_LAST = RUN_W'(CS_RUN - 1);

  logic             crs_q;
  logic [RUN_W-1:0] run_q;

  // Only transitions after carrier is already up carry delivered bits.
  assign bit_evt = mid_evt && crs_q;
  assign crs     = crs_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      crs_q <= 1'b0;
      run_q <= '0;
    end else if (quiet) begin
      crs_q <= 1'b0;
      run_q <= '0;
    end else if (mid_evt && !crs_q) begin
      if (!gap_ok) begin
        run_q <= '0;
      end else if (run_q == RUN_LAST) begin
        crs_q <= 1'b1;
        run_q <= '0;
      end else begin
        run_q <= run_q + 1'b1;
      end
    end
  end

  assert_rise_on_good_edge_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(crs_q) |-> $past(mid_evt && gap_ok));

  assert_fall_on_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(crs_q) |-> $past(quiet));

endmodule

// File: rtl/mrx_assemble.sv
module mrx_assemble #(
  parameter int unsigned DATA_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_evt,
  input  logic              bit_val,
  input  logic              serial_mode,
  input  logic              flush,
  output logic [DATA_W-1:0] rxd,
  output logic              rx_valid
);
  localparam int unsigned IDX_W = $clog2(DATA_W);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(DATA_W - 1);

  logic [DATA_W-2:0] sh_q;
  logic [IDX_W-1:0]  idx_q;
  logic              word_done;

  assign word_done = bit_evt && !serial_mode && (idx_q == IDX_LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rxd      <= '0;
      rx_valid <= 1'b0;
      sh_q     <= '0;
      idx_q    <= '0;
    end else begin
      rx_valid <= 1'b0;
      if (flush) begin
        rxd   <= '0;
        sh_q  <= '0;
        idx_q <= '0;
      end else if (bit_evt) begin
        if (serial_mode) begin
          rxd      <= {{(DATA_W-1){1'b0}}, bit_val};
          rx_valid <= 1'b1;
        end else if (word_done) begin
          rxd      <= {bit_val, sh_q};
          rx_valid <= 1'b1;
          idx_q    <= '0;
        end else begin
          sh_q[idx_q] <= bit_val;
          idx_q       <= idx_q + 1'b1;
        end
      end
    end
  end

  assert_serial_upper_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && serial_mode && $past(serial_mode)) |-> (rxd[DATA_W-1:1] == '0));

  assert_flush_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (rxd == '0) && !rx_valid);

endmodule

// File: rtl/mrx_manchester_rx.sv
module mrx_manchester_rx #(
  parameter int unsigned OSR    = 8,
  parameter int unsigned CS_RUN = 6,
  parameter int unsigned DATA_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              os_en,
  input  logic              line_in,
  input  logic              serial_mode,
  output logic [DATA_W-1:0] rxd,
  output logic              rx_valid,
  output logic              crs
);
  localparam int unsigned CNT_W = $clog2(2 * OSR + 2);

  logic mid_evt;
  logic mid_val;
  logic gap_ok;
  logic quiet;
  logic locked;
  logic bit_evt;

  mrx_edge_track #(.OSR(OSR), .CNT_W(CNT_W)) u_track (
    .clk(clk), .rst_n(rst_n), .os_en(os_en), .line_in(line_in),
    .mid_evt(mid_evt), .mid_val(mid_val), .gap_ok(gap_ok),
    .quiet(quiet), .locked(locked)
  );

  mrx_carrier #(.CS_RUN(CS_RUN)) u_carrier (
    .clk(clk), .rst_n(rst_n), .mid_evt(mid_evt), .gap_ok(gap_ok),
    .quiet(quiet), .crs(crs), .bit_evt(bit_evt)
  );

  mrx_assemble #(.DATA_W(DATA_W)) u_assemble (
    .clk(clk), .rst_n(rst_n), .bit_evt(bit_evt), .bit_val(mid_val),
    .serial_mode(serial_mode), .flush(quiet), .rxd(rxd), .rx_valid(rx_valid)
  );

  assert_crs_has_lock_R4: assert property (@(posedge clk) disable iff (!rst_n)
    crs |-> locked);

  assert_strobe_in_carrier_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> crs);

  assert_idle_data_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !crs |-> (rxd == '0));

endmodule

// File: tb/mrx_manchester_rx_test.sv
module mrx_manchester_rx_test;
  localparam int OSR    = 8;
  localparam int CS_RUN = 6;
  localparam int H      = OSR / 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       os_en = 1'b0;
  logic       line_in = 1'b0;
  logic       serial_mode = 1'b0;
  logic [3:0] rxd;
  logic       rx_valid;
  logic       crs;

  int n_checks = 0;
  int n_fail   = 0;
  int cyc      = 0;
  bit done     = 1'b0;

  logic fq[$];
  logic [3:0] got[$];

  always #4 clk = ~clk;

  mrx_manchester_rx #(.OSR(OSR), .CS_RUN(CS_RUN), .DATA_W(4)) uut (
    .clk(clk), .rst_n(rst_n), .os_en(os_en), .line_in(line_in),
    .serial_mode(serial_mode), .rxd(rxd), .rx_valid(rx_valid), .crs(crs)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Behavioural reference: ticks since last centre edge, run length, word buffer.
  int   since = 0;
  bit   m_ref = 0;
  logic m_prev = 1'b0;
  int   m_run = 0;
  bit   m_crs = 0;
  int   m_acc = 0;
  int   m_cnt = 0;
  int   m_rxd = 0;
  bit   m_valid = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      since = 0; m_ref = 0; m_prev = 1'b0; m_run = 0; m_crs = 0;
      m_acc = 0; m_cnt = 0; m_rxd = 0; m_valid = 0;
    end else begin
      m_valid = 0;
      if (os_en) begin
        bit chg;
        if (since < 60) since = since + 1;
        chg = (line_in != m_prev);
        m_prev = line_in;
        if (chg && (!m_ref || since >= (3 * OSR) / 4)) begin
          bit good;
          good = m_ref && (since <= (5 * OSR) / 4);
          if (m_crs) begin
            if (serial_mode) begin
              m_rxd = int'(line_in);
              m_valid = 1;
            end else begin
              m_acc = m_acc + (int'(line_in) << m_cnt);
              m_cnt = m_cnt + 1;
              if (m_cnt == 4) begin
                m_rxd = m_acc; m_valid = 1; m_acc = 0; m_cnt = 0;
              end
            end
          end else if (good) begin
            m_run = m_run + 1;
            if (m_run == CS_RUN) begin m_crs = 1; m_run = 0; end
          end else begin
            m_run = 0;
          end
          since = 0;
          m_ref = 1;
        end else if (m_ref && since > 2 * OSR) begin
          m_crs = 0; m_ref = 0; m_run = 0; m_acc = 0; m_cnt = 0; m_rxd = 0;
        end
      end
    end
  end

  // Compare against the model every clock, away from the active edge.
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(crs === m_crs, "R4/R5 crs vs model", int'(crs), int'(m_crs));
      chk(rx_valid === m_valid, "R2/R3 rx_valid vs model", int'(rx_valid), int'(m_valid));
      chk(int'(rxd) == m_rxd, "R2/R3/R6 rxd vs model", int'(rxd), m_rxd);
      if (rx_valid) got.push_back(rxd);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1'b1;
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  task automatic tick(input logic v);
    @(negedge clk); line_in = v; os_en = 1'b1;
    @(negedge clk); os_en = 1'b0;
  endtask

  task automatic build(input int pre, input logic [31:0] data, input int nd);
    fq.delete();
    for (int i = 0; i < pre; i++) fq.push_back(~i[0]);
    for (int i = 0; i < nd; i++) fq.push_back(data[i]);
  endtask

  // Manchester: bit b is ~b for the first half and b for the second half.
  task automatic send(input int stretch_at);
    got.delete();
    foreach (fq[i]) begin
      repeat ((i == stretch_at) ? H + 1 : H) tick(~fq[i]);
      repeat (H) tick(fq[i]);
    end
    chk(crs === 1'b1, "R4 carrier up at end of frame", int'(crs), 1);
    repeat (2 * OSR + 6) tick(1'b0);
    chk(crs === 1'b0, "R5 carrier dropped after quiet", int'(crs), 0);
    chk(rxd === 4'd0, "R6 rxd zero after drop", int'(rxd), 0);
  endtask

  task automatic check_words(input string tag);
    int nb;
    int k;
    nb = fq.size() - (CS_RUN + 1);
    k  = serial_mode ? nb : nb / 4;
    chk(got.size() == k, {tag, " word count"}, got.size(), k);
    for (int w = 0; w < k && w < got.size(); w++) begin
      int e;
      e = 0;
      if (serial_mode) e = int'(fq[CS_RUN + 1 + w]);
      else for (int b = 0; b < 4; b++) e = e + (int'(fq[CS_RUN + 1 + 4 * w + b]) << b);
      chk(int'(got[w]) == e, {tag, " word value"}, int'(got[w]), e);
    end
  endtask

  initial begin
    repeat (4) @(negedge clk);
    chk(crs === 1'b0, "R7 reset crs", int'(crs), 0);
    chk(rx_valid === 1'b0, "R7 reset rx_valid", int'(rx_valid), 0);
    chk(rxd === 4'd0, "R7 reset rxd", int'(rxd), 0);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) tick(1'b0);

    // Nibble frame with a leftover partial nibble (25 delivered bits).
    serial_mode = 1'b0;
    build(16, 32'h0000_A5C3, 16);
    send(-1);
    check_words("R1/R2 nibble frame");

    // Next frame must start a fresh word: partial nibble was discarded.
    build(12, 32'h0003_6E91, 18);
    send(-1);
    check_words("R5 fresh word after discard");

    // Serial form.
    serial_mode = 1'b1;
    build(10, 32'h0000_3B7C, 15);
    send(-1);
    check_words("R3 serial frame");

    // Late centre transitions inside the payload.
    serial_mode = 1'b0;
    build(14, 32'h00F0_5A2D, 22);
    send(20);
    check_words("R8 late centre realigned");

    // Slow toggling: every gap too long, carrier must stay down.
    got.delete();
    for (int i = 0; i < 10; i++) repeat (12) tick(i[0]);
    chk(crs === 1'b0, "R4 long gaps give no carrier", int'(crs), 0);
    chk(got.size() == 0, "R6 no strobes without carrier", got.size(), 0);
    repeat (2 * OSR + 6) tick(1'b0);

    // Continuous ones: boundary transitions every bit must be ignored.
    build(8, 32'h0000_FFFF, 17);
    send(-1);
    check_words("R1 boundary edges ignored");

    repeat (4) @(negedge clk);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

endmodule